// File: doc/BRIEF.md
# Far Jump Target Privilege Checker

This block decides whether a protected-mode far jump may go to the descriptor that its selector names. The descriptor has already been fetched and its fields arrive on input pins. The block names the kind of target (conforming code, non-conforming code, call gate, task gate or task state segment). It then runs the selector, type, privilege and presence checks in a fixed order, one check per clock. It reports the first failure as a general-protection or not-present fault, together with the selector that the error code must carry.

A request is started by a one-cycle `start` while the block is idle. All request inputs stay stable until `done` pulses. When the target is a task gate, the descriptor of the task state segment it points to is supplied on the `tss_*` inputs, and one extra check step validates it. On success the block reports the requested privilege level that the new code selector receives. The results stay on the outputs until the next request completes.

Top module: `far_jmp_priv_chk`

## Requirements
- R1: After reset, and whenever reset is asserted, `busy`, `done`, `jump_kind`, `fault`, `fault_sel` and `new_rpl` are all 0.
- R2: The checks run one per clock in this order: null selector, table limit, type, privilege, presence, then (task gate only) task segment. `done` is a one-cycle pulse that comes k clock edges after the edge that accepts `start`. k is the number of the check that failed (1 to 6), 5 when a non-task-gate target passes, and 6 when a task gate passes. `busy` is high from the accepting edge until `done` rises.
- R3: A selector with index 0 and table indicator 0 gives fault 1 (general protection) with `fault_sel` 0. Index 0 with table indicator 1 is not null.
- R4: A selector index greater than `tbl_limit` gives fault 1 with `fault_sel` = {`sel_idx`, `sel_ti`, `sel_rpl`}. An index equal to the limit passes.
- R5: `desc_kind` codes above 4 give fault 1 with the selector. With `lma` high, a task gate (3) or task state segment (4) gives fault 1 with the selector, and so does a code segment (0 or 1) with both `desc_l` and `desc_d` set. With `lma` low, L and D together are allowed.
- R6: A conforming code segment (0) faults 1 with the selector if its DPL exceeds the CPL, and the selector RPL does not matter. A non-conforming code segment (1) faults 1 with the selector if the RPL exceeds the CPL or the DPL differs from the CPL.
- R7: A call gate (2), task gate (3) or task state segment (4) faults 1 with the selector if its DPL is below the CPL or below the selector RPL. A directly named task state segment with `desc_busy` set also faults 1 with the selector.
- R8: If every earlier check passes but `desc_p` is 0, the result is fault 2 (not present) with the selector. A privilege failure takes priority over non-presence.
- R9: For a task gate, the referenced task segment faults 1 with {`tss_idx`, `tss_ti`, `tss_rpl`} if `tss_ti` is 1, if `tss_idx` exceeds `gdt_limit`, or if `tss_busy` is set. Otherwise it faults 2 with that selector if `tss_p` is 0.
- R10: On completion, `jump_kind` equals `desc_kind` (0 conforming, 1 non-conforming, 2 call gate, 3 task gate, 4 task segment). With no fault, `fault` is 0 and `new_rpl` equals the CPL. With a fault, `new_rpl` is 0.
- R11: A `start` pulse while `busy` is high has no effect. Completion timing and results are unchanged, and no second request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a request when idle |
| sel_idx | input | IW | Target selector index |
| sel_ti | input | 1 | Target selector table indicator (1 = local) |
| sel_rpl | input | 2 | Target selector requested privilege |
| cpl | input | 2 | Current privilege level |
| desc_kind | input | 3 | Descriptor class code |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_p | input | 1 | Descriptor present |
| desc_l | input | 1 | Code descriptor 64-bit flag |
| desc_d | input | 1 | Code descriptor default-size flag |
| desc_busy | input | 1 | Task segment busy |
| tbl_limit | input | IW | Highest valid index in the selected table |
| lma | input | 1 | Long mode active |
| tss_idx | input | IW | Task gate's target selector index |
| tss_ti | input | 1 | Task gate's target table indicator |
| tss_rpl | input | 2 | Task gate's target selector privilege |
| tss_busy | input | 1 | Referenced task segment busy |
| tss_p | input | 1 | Referenced task segment present |
| gdt_limit | input | IW | Highest valid global table index |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| jump_kind | output | 3 | Target class of the last request |
| fault | output | 2 | 0 none, 1 general protection, 2 not present |
| fault_sel | output | IW+3 | Error-code selector |
| new_rpl | output | 2 | RPL for the new code selector |

## Verification
The assertions on result values assume that every request input, the CPL among them, holds its value from the accepted `start` until `done`. The checker reads those pins live and does not capture them. The bench keeps to this by applying each vector before raising `start` and changing inputs only after the completion pulse. In the overlapping-start test it pulses only `start` and leaves every field untouched.

// File: rtl/far_jmp_priv_chk.sv
module far_jmp_priv_chk #(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] sel_idx,
  input  logic          sel_ti,
  input  logic [1:0]    sel_rpl,
  input  logic [1:0]    cpl,
  input  logic [2:0]    desc_kind,
  input  logic [1:0]    desc_dpl,
  input  logic          desc_p,
  input  logic          desc_l,
  input  logic          desc_d,
  input  logic          desc_busy,
  input  logic [IW-1:0] tbl_limit,
  input  logic          lma,
  input  logic [IW-1:0] tss_idx,
  input  logic          tss_ti,
  input  logic [1:0]    tss_rpl,
  input  logic          tss_busy,
  input  logic          tss_p,
  input  logic [IW-1:0] gdt_limit,
  output logic          busy,
  output logic          done,
  output logic [2:0]    jump_kind,
  output logic [1:0]    fault,
  output logic [IW+2:0] fault_sel,
  output logic [1:0]    new_rpl
);
  localparam int SW = IW + 3;
  localparam logic [1:0] F_NONE = 2'd0, F_GP = 2'd1, F_NP = 2'd2;
  localparam logic [2:0] K_CONF = 3'd0, K_NCONF = 3'd1, K_TGATE = 3'd3, K_TSS = 3'd4;

  logic [2:0]    step;
  logic          fail, last;
  logic [1:0]    fkind;
  logic [SW-1:0] fsel;

  wire [SW-1:0] tgt_sel = {sel_idx, sel_ti, sel_rpl};
  wire [SW-1:0] tss_sel = {tss_idx, tss_ti, tss_rpl};
  wire          is_code = (desc_kind == K_CONF) || (desc_kind == K_NCONF);

  assign last = (step == 3'd5) || (step == 3'd4 && desc_kind != K_TGATE);

  always_comb begin
    fail  = 1'b0;
    fkind = F_GP;
    fsel  = tgt_sel;
    case (step)
      3'd0: begin
        fail = (sel_idx == '0) && !sel_ti;
        fsel = '0;
      end
      3'd1: fail = sel_idx > tbl_limit;
      3'd2: fail = (desc_kind > K_TSS)
                || (lma && (desc_kind == K_TGATE || desc_kind == K_TSS))
                || (lma && is_code && desc_l && desc_d);
      3'd3: begin
        if (desc_kind == K_CONF)       fail = desc_dpl > cpl;
        else if (desc_kind == K_NCONF) fail = (sel_rpl > cpl) || (desc_dpl != cpl);
        else fail = (desc_dpl < cpl) || (desc_dpl < sel_rpl)
                 || (desc_kind == K_TSS && desc_busy);
      end
      3'd4: begin
        fail  = !desc_p;
        fkind = F_NP;
      end
      default: begin
        fsel = tss_sel;
        if (tss_ti || (tss_idx > gdt_limit) || tss_busy) fail = 1'b1;
        else begin
          fail  = !tss_p;
          fkind = F_NP;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      step      <= '0;
      jump_kind <= '0;
      fault     <= F_NONE;
      fault_sel <= '0;
      new_rpl   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          step <= '0;
        end
      end else if (fail || last) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        jump_kind <= desc_kind;
        fault     <= fail ? fkind : F_NONE;
        fault_sel <= fail ? fsel : '0;
        new_rpl   <= fail ? 2'd0 : cpl;
      end else begin
        step <= step + 3'd1;
      end
    end
  end

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
  a_r10_ok_rpl: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == F_NONE) |-> (new_rpl == cpl && jump_kind == desc_kind));
  a_r5_long_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == F_NONE && lma) |-> (jump_kind <= 3'd2));
  a_r3_null_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sel_idx == '0 && !sel_ti) |-> (fault == F_GP && fault_sel == '0));
  a_r8_np_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == F_NP && jump_kind != K_TGATE) |-> (fault_sel == tgt_sel));
endmodule

// File: tb/tb_far_jmp_priv_chk.sv
module tb_far_jmp_priv_chk;
  localparam int IW = 4;

  typedef struct packed {
    logic [3:0] idx; logic ti; logic [1:0] rpl; logic [1:0] cpl;
    logic [2:0] kind; logic [1:0] dpl; logic p; logic l; logic d; logic bsy;
    logic [3:0] lim; logic lma;
    logic [3:0] tidx; logic tti; logic [1:0] trpl; logic tbsy; logic tp; logic [3:0] glim;
    logic [1:0] ef; logic [1:0] es; logic [3:0] en; logic [3:0] rq;
  } vec_t;

  // fields: idx ti rpl cpl kind dpl p l d bsy lim lma | tidx tti trpl tbsy tp glim | fault selsrc(0 zero,1 target,2 tss) n req
  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{0,0,0,2, 0,0,1,0,0,0, 5,0, 2,0,0,0,1,5, 1,0,2,3},  // R3 null
    '{0,1,2,2, 0,1,1,0,0,0, 5,0, 2,0,0,0,1,5, 0,0,6,3},  // R3 local idx 0
    '{6,0,1,2, 1,2,1,0,0,0, 5,0, 2,0,0,0,1,5, 1,1,3,4},  // R4 beyond limit
    '{5,0,2,2, 1,2,1,0,0,0, 5,0, 2,0,0,0,1,5, 0,0,6,4},  // R4 at limit
    '{1,0,0,2, 5,2,1,0,0,0, 5,0, 2,0,0,0,1,5, 1,1,4,5},  // R5 bad kind
    '{1,0,0,2, 3,3,1,0,0,0, 5,1, 2,0,0,0,1,5, 1,1,4,5},  // R5 long task gate
    '{1,0,0,2, 4,3,1,0,0,0, 5,1, 2,0,0,0,1,5, 1,1,4,5},  // R5 long tss
    '{1,0,0,2, 0,0,1,1,1,0, 5,1, 2,0,0,0,1,5, 1,1,4,5},  // R5 long L+D
    '{1,0,0,2, 0,0,1,1,1,0, 5,0, 2,0,0,0,1,5, 0,0,6,5},  // R5 legacy L+D ok
    '{1,0,0,2, 2,2,1,0,0,0, 5,1, 2,0,0,0,1,5, 0,0,6,5},  // R5 long call gate
    '{2,0,0,2, 0,3,1,0,0,0, 5,0, 2,0,0,0,1,5, 1,1,5,6},  // R6 conf dpl>cpl
    '{2,0,3,2, 0,0,1,0,0,0, 5,0, 2,0,0,0,1,5, 0,0,6,6},  // R6 conf rpl ignored
    '{2,0,3,2, 1,2,1,0,0,0, 5,0, 2,0,0,0,1,5, 1,1,5,6},  // R6 nconf rpl>cpl
    '{2,0,2,2, 1,1,1,0,0,0, 5,0, 2,0,0,0,1,5, 1,1,5,6},  // R6 nconf dpl!=cpl
    '{2,0,1,1, 1,1,1,0,0,0, 5,0, 2,0,0,0,1,5, 0,0,6,6},  // R6 nconf ok
    '{3,0,0,2, 2,1,1,0,0,0, 5,0, 2,0,0,0,1,5, 1,1,5,7},  // R7 gate dpl<cpl
    '{3,0,3,2, 2,2,1,0,0,0, 5,0, 2,0,0,0,1,5, 1,1,5,7},  // R7 gate dpl<rpl
    '{3,0,2,2, 4,3,1,0,0,1, 5,0, 2,0,0,0,1,5, 1,1,5,7},  // R7 tss busy
    '{3,0,2,2, 4,3,1,0,0,0, 5,0, 2,0,0,0,1,5, 0,0,6,7},  // R7 tss ok
    '{4,0,2,2, 1,2,0,0,0,0, 5,0, 2,0,0,0,1,5, 2,1,6,8},  // R8 not present
    '{4,0,2,2, 1,1,0,0,0,0, 5,0, 2,0,0,0,1,5, 1,1,5,8},  // R8 priv wins
    '{4,0,0,2, 3,2,0,0,0,0, 5,0, 2,1,0,0,1,5, 2,1,6,8},  // R8 gate absent first
    '{4,1,1,2, 3,2,1,0,0,0, 5,0, 2,0,0,0,1,5, 0,0,7,9},  // R9 task gate ok
    '{4,1,1,2, 3,2,1,0,0,0, 5,0, 2,1,1,0,1,5, 1,2,7,9},  // R9 local tss
    '{4,1,1,2, 3,2,1,0,0,0, 5,0, 6,0,0,0,1,5, 1,2,7,9},  // R9 tss beyond gdt
    '{4,1,1,2, 3,2,1,0,0,0, 5,0, 2,0,2,1,1,5, 1,2,7,9},  // R9 tss busy
    '{4,1,1,2, 3,2,1,0,0,0, 5,0, 2,0,3,0,0,5, 2,2,7,9},  // R9 tss absent
    '{4,1,1,2, 3,2,1,0,0,0, 5,0, 5,0,0,0,1,5, 0,0,7,9}   // R9 tss at gdt limit
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [IW-1:0] sel_idx = '0, tbl_limit = '0, tss_idx = '0, gdt_limit = '0;
  logic sel_ti = 0, desc_p = 0, desc_l = 0, desc_d = 0, desc_busy = 0, lma = 0;
  logic tss_ti = 0, tss_busy = 0, tss_p = 0;
  logic [1:0] sel_rpl = '0, cpl = '0, desc_dpl = '0, tss_rpl = '0;
  logic [2:0] desc_kind = '0;
  logic busy, done;
  logic [2:0] jump_kind;
  logic [1:0] fault, new_rpl;
  logic [IW+2:0] fault_sel;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  far_jmp_priv_chk #(.IW(IW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_idx(sel_idx), .sel_ti(sel_ti),
    .sel_rpl(sel_rpl), .cpl(cpl), .desc_kind(desc_kind), .desc_dpl(desc_dpl),
    .desc_p(desc_p), .desc_l(desc_l), .desc_d(desc_d), .desc_busy(desc_busy),
    .tbl_limit(tbl_limit), .lma(lma), .tss_idx(tss_idx), .tss_ti(tss_ti),
    .tss_rpl(tss_rpl), .tss_busy(tss_busy), .tss_p(tss_p), .gdt_limit(gdt_limit),
    .busy(busy), .done(done), .jump_kind(jump_kind), .fault(fault),
    .fault_sel(fault_sel), .new_rpl(new_rpl)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    sel_idx = v.idx; sel_ti = v.ti; sel_rpl = v.rpl; cpl = v.cpl;
    desc_kind = v.kind; desc_dpl = v.dpl; desc_p = v.p; desc_l = v.l; desc_d = v.d;
    desc_busy = v.bsy; tbl_limit = v.lim; lma = v.lma;
    tss_idx = v.tidx; tss_ti = v.tti; tss_rpl = v.trpl; tss_busy = v.tbsy;
    tss_p = v.tp; gdt_limit = v.glim;
  endtask

  task automatic run(input vec_t v, input bit poke, input string req);
    int n;
    logic [IW+2:0] esel;
    apply(v);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; n = 1;
    while (!done && n < 20) begin
      @(negedge clk); n++;
      if (poke) start = (n == 3);
    end
    start = 1'b0;
    esel = (v.es == 2'd1) ? {v.idx, v.ti, v.rpl} :
           (v.es == 2'd2) ? {v.tidx, v.tti, v.trpl} : '0;
    check(n == int'(v.en), req, "R2 latency", n, v.en);
    check(fault == v.ef, req, "fault", fault, v.ef);
    check(fault_sel == esel, req, "fault_sel", fault_sel, esel);
    check(jump_kind == v.kind, req, "R10 jump_kind", jump_kind, v.kind);
    check(new_rpl == ((v.ef == 0) ? v.cpl : 2'd0), req, "R10 new_rpl", new_rpl,
          (v.ef == 0) ? v.cpl : 0);
    @(negedge clk);
    check(!done && !busy, req, "R2 single pulse, idle", {done, busy}, 0);
  endtask

  initial begin
    #1ms;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && fault == 0 && fault_sel == 0 && jump_kind == 0 && new_rpl == 0,
          "R1", "reset outputs", {busy, done, fault, jump_kind, new_rpl}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1", "idle after release", {busy, done}, 0);

    for (int i = 0; i < NV; i++) run(VEC[i], 1'b0, $sformatf("R%0d vec%0d", VEC[i].rq, i));

    // R11 start pulse while busy on a task gate request
    run(VEC[22], 1'b1, "R11");
    // R11 again on a null fault path
    run(VEC[0], 1'b0, "R11 follow-up");

    // R1 reset mid-request clears everything
    run(VEC[19], 1'b0, "R1 preload");
    apply(VEC[22]);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !done && fault == 0 && fault_sel == 0 && jump_kind == 0 && new_rpl == 0,
          "R1", "mid-request reset", {busy, done, fault, jump_kind, new_rpl}, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    check(!busy && !done, "R1", "no resume after reset", {busy, done}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule